// File: doc/BRIEF.md
# Chained-Descriptor Receive DMA Channel

This block moves a byte stream into memory by walking a ring of packet descriptors that the host has laid out in a local memory. Each descriptor names a data buffer and the next descriptor in the chain. The channel takes bytes from a valid/ready stream and stores them in the current buffer. When a frame ends or the buffer is full, it writes the byte count and a status byte back into the descriptor. After that write it moves on along the chain.

The host controls the channel through a small register write port and sees its position on output pins. `cur_desc` is the descriptor the engine owns next. `end_desc` is the stop point: the engine never processes the descriptor it names. To extend the ring, the host moves `end_desc` forward. Memory access uses a byte-wide request/grant port. A request stays asserted until the cycle in which it is granted, and read data returns in that same cycle.

Register write map (`reg_addr`): 0 current descriptor offset, 1 end descriptor offset, 2 buffer length limit, 3 descriptor page base, 4 status (bits 3:0 write-one-to-clear, bit 4 enable), 5 interrupt enables (bit 0 end-of-frame, bit 1 overflow), 6 command (bit 0 abort, bit 1 clear frame counter).

Top module: `ring_rx_dma`

## Requirements
- R1: The descriptor at byte address {base, cur_desc} holds the following fields. Bytes 0-1 are the little-endian chain offset. Bytes 2-5 are the little-endian buffer address. Bytes 6-7 are the byte count. Byte 8 is the status byte. Received byte k of a buffer is stored at buffer address + k.
- R2: The engine works only while the enable bit is set and `cur_desc` differs from `end_desc`. When it advances onto `end_desc`, it sets the end-of-transfer flag (`dma_status[0]`).
- R3: A buffer is closed either when it holds as many bytes as the length limit or when a byte marked `in_last` is stored. A buffer closed by the limit gets status byte 0x00 and count equal to the limit; the frame continues in the next descriptor. A buffer closed by `in_last` gets status byte 0x80 and its actual count.
- R4: `cur_desc` takes the chain offset in the same cycle that the status byte write-back is granted. It never changes before that write.
- R5: Each completed frame sets the end-of-frame flag (`dma_status[1]`) and increments `frame_count`.
- R6: While the channel is enabled and `cur_desc` equals `end_desc`, incoming bytes are accepted and discarded. Each discarded byte sets the overflow flag (`dma_status[2]`) and makes no memory access.
- R7: `frame_count` wraps after 2^FCNT_W frames and sets the counter-overflow flag (`dma_status[3]`). Command bit 1 clears the counter.
- R8: A status write clears each flag whose bit 3:0 is one and leaves the others. Bit 4 of the write sets the enable (`dma_status[4]`). With enable low, `in_ready` and `mem_req` stay low and the engine keeps its place.
- R9: Command bit 0 aborts the channel. It returns the engine to idle, clears enable and all flags, and discards the partly filled buffer without writing its descriptor back.
- R10: `irq` is high when the end-of-frame flag is set with enable bit 0 of the interrupt-enable register, or when the overflow flag is set with enable bit 1.
- R11: An ungranted memory request keeps its address and direction on the next cycle unless the host writes a register.
- R12: After reset, `cur_desc`, `end_desc`, `dma_status`, `frame_count`, `irq`, `in_ready` and `mem_req` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 16 | Register write data |
| cur_desc | output | 16 | Current descriptor offset |
| end_desc | output | 16 | End descriptor offset |
| dma_status | output | 5 | {enable, counter overflow, overflow, end of frame, end of transfer} |
| frame_count | output | FCNT_W | Completed frame counter |
| irq | output | 1 | Interrupt request |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Byte ends a frame |
| in_ready | output | 1 | Stream byte accepted |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write when high, read when low |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_gnt | input | 1 | Memory access done this cycle |
| mem_rdata | input | 8 | Memory read data, valid with grant |

## Verification
Directed frames of a few bytes, of exactly the length limit, and of one byte past it separate the three ways a buffer can close. Random frame lengths with random stream gaps and random memory grants check that ring position, write-back counts and stored bytes stay consistent across spills and wraps. A frame longer than the free ring separates end-of-transfer from overflow and proves that discarded bytes leave memory untouched. Halt, abort and sixteen one-byte frames exercise the control flags, the write-one-to-clear masking and the counter wrap.

// File: rtl/ring_rx_dma.sv
module ring_rx_dma #(
  parameter int BASE_W = 8,
  parameter int FCNT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       cur_desc,
  output logic [15:0]       end_desc,
  output logic [4:0]        dma_status,
  output logic [FCNT_W-1:0] frame_count,
  output logic              irq,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic              mem_gnt,
  input  logic [7:0]        mem_rdata
);
  localparam int PAD_W = 32 - BASE_W - 16;
  localparam logic [2:0] A_CDA = 3'd0, A_EDA = 3'd1, A_BFL = 3'd2, A_BASE = 3'd3,
                         A_STAT = 3'd4, A_IEN = 3'd5, A_CMD = 3'd6;
  localparam logic [7:0] EOM_BYTE = 8'h80;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_RECV, S_STORE, S_WB} st_t;
  st_t st;

  logic [15:0] cda, eda, bfl, chain, cnt;
  logic [BASE_W-1:0] base;
  logic [31:0] bptr;
  logic [7:0] hold;
  logic last_q, en, f_eot, f_eom, f_bof, f_cof;
  logic [2:0] idx;
  logic [1:0] ien;
  logic [FCNT_W-1:0] fcnt;

  wire wr_stat = reg_we && reg_addr == A_STAT;
  wire abort   = reg_we && reg_addr == A_CMD && reg_wdata[0];
  wire fclr    = reg_we && reg_addr == A_CMD && reg_wdata[1];
  wire [3:0] clr = wr_stat ? reg_wdata[3:0] : 4'd0;

  assign in_ready = en && (st == S_RECV || (st == S_IDLE && cda == eda));
  assign mem_req  = en && (st == S_FETCH || st == S_STORE || st == S_WB);
  assign mem_we   = st != S_FETCH;
  wire acc      = in_valid && in_ready;
  wire gnt_ok   = mem_req && mem_gnt;
  wire wb_done  = st == S_WB && gnt_ok && idx == 3'd2;
  wire set_eom  = wb_done && last_q;
  wire buf_end  = last_q || (cnt + 16'd1 == bfl);

  assign cur_desc    = cda;
  assign end_desc    = eda;
  assign dma_status  = {en, f_cof, f_bof, f_eom, f_eot};
  assign frame_count = fcnt;
  assign irq         = (f_eom && ien[0]) || (f_bof && ien[1]);

  always_comb begin
    mem_addr  = {{PAD_W{1'b0}}, base, cda + {13'd0, idx}};
    mem_wdata = hold;
    if (st == S_STORE) mem_addr = bptr + {16'd0, cnt};
    if (st == S_WB) begin
      mem_addr = {{PAD_W{1'b0}}, base, cda + 16'd6 + {13'd0, idx}};
      case (idx)
        3'd0:    mem_wdata = cnt[7:0];
        3'd1:    mem_wdata = cnt[15:8];
        default: mem_wdata = last_q ? EOM_BYTE : 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cda <= '0; eda <= '0; bfl <= '0; base <= '0; chain <= '0;
      bptr <= '0; cnt <= '0; hold <= '0; last_q <= 1'b0; idx <= '0; ien <= '0;
      en <= 1'b0; f_eot <= 1'b0; f_eom <= 1'b0; f_bof <= 1'b0; f_cof <= 1'b0;
    end else if (abort) begin
      st <= S_IDLE; cnt <= '0; idx <= '0; en <= 1'b0;
      f_eot <= 1'b0; f_eom <= 1'b0; f_bof <= 1'b0; f_cof <= 1'b0;
    end else begin
      f_eot <= (f_eot && !clr[0]) || (wb_done && chain == eda);
      f_eom <= (f_eom && !clr[1]) || set_eom;
      f_bof <= (f_bof && !clr[2]) || (acc && st == S_IDLE);
      f_cof <= (f_cof && !clr[3]) || (set_eom && &fcnt);
      if (wr_stat) en <= reg_wdata[4];
      case (st)
        S_IDLE: if (en && cda != eda) begin st <= S_FETCH; idx <= '0; end
        S_FETCH: if (gnt_ok) begin
          case (idx)
            3'd0: chain[7:0]   <= mem_rdata;
            3'd1: chain[15:8]  <= mem_rdata;
            3'd2: bptr[7:0]    <= mem_rdata;
            3'd3: bptr[15:8]   <= mem_rdata;
            3'd4: bptr[23:16]  <= mem_rdata;
            default: bptr[31:24] <= mem_rdata;
          endcase
          idx <= idx + 3'd1;
          if (idx == 3'd5) st <= S_RECV;
        end
        S_RECV: if (acc) begin hold <= in_data; last_q <= in_last; st <= S_STORE; end
        S_STORE: if (gnt_ok) begin
          cnt <= cnt + 16'd1;
          idx <= '0;
          st  <= buf_end ? S_WB : S_RECV;
        end
        S_WB: if (gnt_ok) begin
          idx <= idx + 3'd1;
          if (idx == 3'd2) begin st <= S_IDLE; cda <= chain; cnt <= '0; end
        end
        default: st <= S_IDLE;
      endcase
      if (reg_we)
        case (reg_addr)
          A_CDA:  cda  <= reg_wdata;
          A_EDA:  eda  <= reg_wdata;
          A_BFL:  bfl  <= reg_wdata;
          A_BASE: base <= reg_wdata[BASE_W-1:0];
          A_IEN:  ien  <= reg_wdata[1:0];
          default: ;
        endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || fclr) fcnt <= '0;
    else if (set_eom && !abort) fcnt <= fcnt + 1'b1;
  end
endmodule

// File: rtl/ring_rx_dma_chk.sv
module ring_rx_dma_chk #(
  parameter int BASE_W = 8,
  parameter int FCNT_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [2:0]        reg_addr,
  input logic [15:0]       cur_desc,
  input logic [15:0]       end_desc,
  input logic [4:0]        dma_status,
  input logic [FCNT_W-1:0] frame_count,
  input logic              in_valid,
  input logic              in_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic [31:0]       mem_addr,
  input logic              mem_gnt,
  input logic [BASE_W-1:0] base
);
  localparam int PAD_W = 32 - BASE_W - 16;

  // R4
  desc_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($changed(cur_desc) && !$past(reg_we && reg_addr == 3'd0)) |->
    ($past(mem_req && mem_we && mem_gnt) &&
     $past(mem_addr) == {{PAD_W{1'b0}}, $past(base), 16'($past(cur_desc) + 16'd8)}));

  // R2
  eot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_status[0]) |-> cur_desc == end_desc);

  // R6
  bof_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_status[2]) |-> $past(in_valid && in_ready && cur_desc == end_desc));

  // R6
  drop_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && cur_desc == end_desc) |-> !mem_req);

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt && !reg_we) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R7
  fcnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($changed(frame_count) && !$past(reg_we && reg_addr == 3'd6)) |->
    frame_count == FCNT_W'($past(frame_count) + 1'b1));

  // R8
  halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_status[4] |-> (!in_ready && !mem_req));
endmodule

bind ring_rx_dma ring_rx_dma_chk #(.BASE_W(BASE_W), .FCNT_W(FCNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .cur_desc(cur_desc), .end_desc(end_desc), .dma_status(dma_status),
  .frame_count(frame_count), .in_valid(in_valid), .in_ready(in_ready),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
  .base(base)
);

// File: tb/test_ring_rx_dma.sv
module test_ring_rx_dma;
  localparam int FCNT_W = 4;
  localparam int NDESC = 4;
  localparam int BFL = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] cur_desc, end_desc;
  logic [4:0] dma_status;
  logic [FCNT_W-1:0] frame_count;
  logic irq, in_ready, mem_req, mem_we;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = '0;
  logic [31:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic gnt_en = 1'b0;
  logic mem_gnt;

  logic [7:0] mem [0:4095];
  logic [7:0] exp_buf [0:255];
  logic [15:0] exp_len [0:NDESC-1];
  logic [7:0] exp_st [0:NDESC-1];
  int m_idx, m_cnt, m_end, m_frames;
  logic e_en, e_eot, e_eom, e_bof, e_cof;
  int vectors = 0, fails = 0;

  ring_rx_dma #(.BASE_W(8), .FCNT_W(FCNT_W)) i_ring_rx_dma (.*);

  always #5 clk = ~clk;
  assign mem_rdata = mem[mem_addr[11:0]];
  assign mem_gnt = mem_req && gnt_en;
  always @(posedge clk) if (mem_req && mem_we && mem_gnt) mem[mem_addr[11:0]] <= mem_wdata;
  always @(negedge clk) gnt_en <= ($urandom % 10) < 7;

  task automatic chk(string req, int act, int expv, string what);
    vectors++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic settle();
    repeat (40) @(negedge clk);
  endtask

  function automatic logic [4:0] exp_status();
    return {e_en, e_cof, e_bof, e_eom, e_eot};
  endfunction

  // model of one accepted byte, from R3, R5, R6, R7
  task automatic model_byte(logic [7:0] d, logic l);
    if (m_idx == m_end) e_bof = 1'b1;
    else begin
      exp_buf[m_idx*64 + m_cnt] = d;
      m_cnt++;
      if (l || m_cnt == BFL) begin
        exp_len[m_idx] = 16'(m_cnt);
        exp_st[m_idx] = l ? 8'h80 : 8'h00;
        m_idx = (m_idx + 1) % NDESC;
        m_cnt = 0;
        if (m_idx == m_end) e_eot = 1'b1;
        if (l) begin
          e_eom = 1'b1;
          if (m_frames == 15) e_cof = 1'b1;
          m_frames = (m_frames + 1) % 16;
        end
      end
    end
  endtask

  task automatic push(logic [7:0] d, logic l);
    logic r;
    in_valid = 1'b1; in_data = d; in_last = l;
    do begin r = in_ready; @(negedge clk); end while (!r);
    model_byte(d, l);
  endtask

  task automatic send_frame(int len);
    for (int i = 0; i < len; i++) begin
      if ($urandom % 4 == 0) begin in_valid = 1'b0; @(negedge clk); end
      push(8'($urandom), i == len - 1);
    end
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic extend();
    m_end = (m_idx + 3) % NDESC;
    wr(3'd1, 16'(m_end * 16));
  endtask

  task automatic clear_flags();
    wr(3'd4, 16'h001F);
    e_eot = 0; e_eom = 0; e_bof = 0; e_cof = 0; e_en = 1;
  endtask

  task automatic verify(string tag);
    int errs = 0;
    for (int i = 0; i < NDESC; i++) begin
      chk("R3", {mem[i*16+7], mem[i*16+6]}, exp_len[i], $sformatf("%s count desc %0d", tag, i));
      chk("R3", mem[i*16+8], exp_st[i], $sformatf("%s status desc %0d", tag, i));
    end
    for (int j = 0; j < 256; j++) if (mem[12'h400 + j] !== exp_buf[j]) errs++;
    chk("R1", errs, 0, {tag, " buffer byte mismatches"});
    chk("R4", cur_desc, m_idx * 16, {tag, " cur_desc"});
    chk("R5", dma_status, exp_status(), {tag, " status flags"});
    chk("R5", frame_count, m_frames, {tag, " frame_count"});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int bad;
    void'($urandom(32'd20240611));
    for (int a = 0; a < 4096; a++) mem[a] = 8'hEE;
    for (int i = 0; i < NDESC; i++) begin
      mem[i*16]   = 8'(((i + 1) % NDESC) * 16); mem[i*16+1] = 8'h00;
      mem[i*16+2] = 8'(i * 64); mem[i*16+3] = 8'h04; mem[i*16+4] = 8'h00; mem[i*16+5] = 8'h00;
      mem[i*16+6] = 8'hAA; mem[i*16+7] = 8'hAA; mem[i*16+8] = 8'h55;
      exp_len[i] = 16'hAAAA; exp_st[i] = 8'h55;
    end
    for (int j = 0; j < 256; j++) exp_buf[j] = 8'hEE;
    m_idx = 0; m_cnt = 0; m_end = 0; m_frames = 0;
    e_en = 0; e_eot = 0; e_eom = 0; e_bof = 0; e_cof = 0;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12", dma_status, 0, "status after reset");
    chk("R12", {cur_desc, end_desc}, 0, "descriptor pointers after reset");
    chk("R12", {irq, in_ready, mem_req}, 0, "irq/in_ready/mem_req after reset");
    chk("R12", frame_count, 0, "frame_count after reset");

    wr(3'd3, 16'h0000);
    wr(3'd2, 16'(BFL));
    wr(3'd0, 16'h0000);
    wr(3'd5, 16'h0001);
    m_end = 3; wr(3'd1, 16'h0030);
    wr(3'd4, 16'h0010); e_en = 1;

    // R1 R3 short frame and frame of exactly the limit
    send_frame(5);
    send_frame(BFL);
    settle();
    verify("short+exact");
    chk("R10", irq, 1, "irq on end-of-frame with enable bit 0");

    // R3 spill by one byte
    clear_flags(); extend();
    send_frame(BFL + 1);
    settle();
    verify("spill");

    // R2 R3 random lengths, gaps and grants
    for (int r = 0; r < 8; r++) begin
      int nf;
      clear_flags(); extend();
      nf = 1 + $urandom % 2;
      for (int f = 0; f < nf; f++) send_frame(1 + $urandom % 24);
      settle();
      verify($sformatf("random%0d", r));
    end

    // R6 overflow past the end descriptor, then R8 and R10 masking
    clear_flags(); extend();
    wr(3'd5, 16'h0002);
    send_frame(3 * BFL + 5);
    settle();
    verify("overflow");
    chk("R6", dma_status[2], 1, "overflow flag after dropped bytes");
    chk("R2", dma_status[0], 1, "end-of-transfer flag at end descriptor");
    chk("R10", irq, 1, "irq on overflow with enable bit 1");
    wr(3'd4, 16'h0014); e_bof = 0;
    chk("R8", dma_status, exp_status(), "clear overflow only");
    chk("R10", irq, 0, "irq after overflow cleared");

    // R8 halt
    clear_flags(); extend();
    wr(3'd4, 16'h0000); e_en = 0;
    chk("R8", dma_status, exp_status(), "status after halt write");
    bad = 0;
    in_valid = 1'b1; in_data = 8'h5A;
    for (int c = 0; c < 10; c++) begin
      if (in_ready || mem_req) bad++;
      @(negedge clk);
    end
    in_valid = 1'b0;
    chk("R8", bad, 0, "cycles with in_ready or mem_req while halted");
    wr(3'd4, 16'h0010); e_en = 1;
    send_frame(4);
    settle();
    verify("halt-resume");

    // R9 abort mid-buffer
    clear_flags(); extend();
    push(8'h11, 1'b0); push(8'h22, 1'b0); push(8'h33, 1'b0);
    in_valid = 1'b0;
    settle();
    wr(3'd6, 16'h0001);
    m_cnt = 0; e_en = 0; e_eot = 0; e_eom = 0; e_bof = 0; e_cof = 0;
    chk("R9", dma_status, 0, "status after abort");
    chk("R9", in_ready, 0, "in_ready after abort");
    wr(3'd4, 16'h0010); e_en = 1;
    send_frame(4);
    settle();
    verify("abort-restart");

    // R7 counter clear, wrap and counter-overflow flag
    wr(3'd6, 16'h0002); m_frames = 0;
    chk("R7", frame_count, 0, "frame_count after clear command");
    clear_flags();
    for (int f = 0; f < 16; f++) begin
      extend();
      send_frame(1);
      settle();
    end
    verify("wrap");
    chk("R7", dma_status[3], 1, "counter-overflow flag after 16 frames");
    wr(3'd6, 16'h0002); m_frames = 0;
    chk("R7", frame_count, 0, "frame_count after second clear");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule